// File: doc/BRIEF.md
# Shifted Operand Barrel Shifter

This block builds the second source operand of a data-processing unit from a 32-bit register value. The caller selects one of five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. The caller also supplies a 6-bit shift amount and the current carry flag. The block returns the shifted value and a shifter carry-out, which a flag unit can use for logical operations.

The block is purely combinational and has no clock and no state. Results follow the inputs in the same cycle. The behaviour is defined for every combination of kind code, amount and carry, including amount zero, amounts of 32 and above, and the three unused kind codes.

The kind field is 3 bits wide and uses these codes:

| Code | Shift kind |
|------|------------|
| 0 | Logical shift left |
| 1 | Logical shift right |
| 2 | Arithmetic shift right |
| 3 | Rotate right |
| 4 | Rotate right one place through carry |
| 5 to 7 | Unused |

Top module: `barrel_shifter`

## Requirements
- R1: With kind code 0, 1, 2 or 3 and an amount of zero, the result equals the operand and the carry-out equals the carry input.
- R2: With kind code 0 (logical left) and an amount n from 1 to 31, the result is the operand shifted left by n with zeros in the vacated low bits, and the carry-out is operand bit 32-n.
- R3: With kind code 0 or 1 and an amount of 32 or more, the result is zero. At exactly 32 the carry-out is operand bit 0 for code 0 and operand bit 31 for code 1. Above 32 the carry-out is 0.
- R4: With kind code 1 (logical right) and an amount n from 1 to 31, the result is the operand shifted right by n with zeros in the vacated high bits, and the carry-out is operand bit n-1.
- R5: With kind code 2 (arithmetic right) and an amount n from 1 to 31, the vacated high bits take copies of operand bit 31 and the carry-out is operand bit n-1. For amounts of 32 or more, every result bit and the carry-out equal operand bit 31.
- R6: With kind code 3 (rotate right) and a nonzero amount, the operand is rotated right by the amount modulo 32, and the carry-out equals result bit 31. In particular, an amount of 32 returns the operand unchanged with carry-out equal to operand bit 31.
- R7: With kind code 4 (rotate right one place through carry), the amount has no effect. Result bit 31 is the carry input, result bits 30..0 are operand bits 31..1, and the carry-out is operand bit 0.
- R8: Kind codes 5, 6 and 7 pass the operand through unchanged, with the carry-out equal to the carry input, for any amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Register value to be shifted |
| kind_i | input | 3 | Shift kind code (see table above) |
| amount_i | input | 6 | Shift amount, 0 to 63 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Both outputs are combinational, so each result is due in the same cycle that its inputs are applied, with no register in the path. The bench applies each operand, kind, amount and carry combination and waits a fixed settling delay before sampling the outputs. It changes no input until that comparison is done. Expected values come from shift and rotate arithmetic written in the bench. The sweep covers all eight kind codes, every amount from 0 to 63, eight operand patterns and both carry values.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_LSL = 3'd0,
    KIND_LSR = 3'd1,
    KIND_ASR = 3'd2,
    KIND_ROR = 3'd3,
    KIND_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bsh_stage.sv
// One power-of-two stage: shift right by S with fill, or rotate right by S.
module bsh_stage #(
  parameter int unsigned W = 33,
  parameter int unsigned S = 1
) (
  input  logic [W-1:0] in_i,
  input  logic         en_i,
  input  logic         rot_i,
  input  logic         fill_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] shifted;
  logic [W-1:0] rotated;

  assign shifted = {{S{fill_i}}, in_i[W-1:S]};
  assign rotated = {in_i[S-1:0], in_i[W-1:S]};
  assign out_o   = !en_i ? in_i : (rot_i ? rotated : shifted);
endmodule

// File: rtl/bsh_rshift.sv
// Right shift with fill on a DW+1 vector; the guard bit below bit 0 catches the last bit out.
module bsh_rshift #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic [DW-1:0] data_i,
  input  logic          fill_i,
  input  logic [AW-1:0] amt_i,
  output logic [DW-1:0] data_o,
  output logic          carry_o
);
  localparam int unsigned W = DW + 1;

  logic [W-1:0] vec [AW+1];

  assign vec[0] = {data_i, 1'b0};

  for (genvar g = 0; g < AW; g++) begin : g_stage
    localparam int unsigned S = 1 << g;
    if (S < W) begin : g_part
      bsh_stage #(.W(W), .S(S)) u_stage (
        .in_i  (vec[g]),
        .en_i  (amt_i[g]),
        .rot_i (1'b0),
        .fill_i(fill_i),
        .out_o (vec[g+1])
      );
    end else begin : g_full
      assign vec[g+1] = amt_i[g] ? {W{fill_i}} : vec[g];
    end
  end

  assign data_o  = vec[AW][W-1:1];
  assign carry_o = vec[AW][0];
endmodule

// File: rtl/bsh_rotr.sv
// Rotate right by amt_i modulo DW.
module bsh_rotr #(
  parameter int unsigned DW = 32,
  localparam int unsigned RW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  logic [RW-1:0] amt_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] vec [RW+1];

  assign vec[0] = data_i;

  for (genvar g = 0; g < RW; g++) begin : g_stage
    bsh_stage #(.W(DW), .S(1 << g)) u_stage (
      .in_i  (vec[g]),
      .en_i  (amt_i[g]),
      .rot_i (1'b1),
      .fill_i(1'b0),
      .out_o (vec[g+1])
    );
  end

  assign data_o = vec[RW];
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic [DW-1:0]     operand_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [AW-1:0]     amount_i,
  input  logic              carry_i,
  output logic [DW-1:0]     result_o,
  output logic              carry_o
);
  localparam int unsigned RW = $clog2(DW);

  logic [DW-1:0] op_rev, lsl_rev, lsl_res, sr_res, ror_res;
  logic          lsl_c, sr_c, sr_fill, amt_zero;

  // Left shift reuses the right shifter on the bit-reversed operand.
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign op_rev[i]  = operand_i[DW-1-i];
    assign lsl_res[i] = lsl_rev[DW-1-i];
  end

  bsh_rshift #(.DW(DW), .AW(AW)) u_lsl (
    .data_i (op_rev),
    .fill_i (1'b0),
    .amt_i  (amount_i),
    .data_o (lsl_rev),
    .carry_o(lsl_c)
  );

  assign sr_fill = (kind_i == KIND_ASR) & operand_i[DW-1];

  bsh_rshift #(.DW(DW), .AW(AW)) u_sr (
    .data_i (operand_i),
    .fill_i (sr_fill),
    .amt_i  (amount_i),
    .data_o (sr_res),
    .carry_o(sr_c)
  );

  bsh_rotr #(.DW(DW)) u_ror (
    .data_i(operand_i),
    .amt_i (amount_i[RW-1:0]),
    .data_o(ror_res)
  );

  assign amt_zero = (amount_i == '0);

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    case (kind_i)
      KIND_LSL: if (!amt_zero) begin
        result_o = lsl_res;
        carry_o  = lsl_c;
      end
      KIND_LSR, KIND_ASR: if (!amt_zero) begin
        result_o = sr_res;
        carry_o  = sr_c;
      end
      KIND_ROR: if (!amt_zero) begin
        result_o = ror_res;
        carry_o  = ror_res[DW-1];
      end
      KIND_RRX: begin
        result_o = {carry_i, operand_i[DW-1:1]};
        carry_o  = operand_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input logic [DW-1:0] operand_i,
  input logic [2:0]    kind_i,
  input logic [AW-1:0] amount_i,
  input logic          carry_i,
  input logic [DW-1:0] result_o,
  input logic          carry_o
);
  logic [DW-1:0] low_mask;
  logic [DW-1:0] high_mask;

  always_comb begin
    low_mask  = (DW'(1) << amount_i) - DW'(1);
    high_mask = ~({DW{1'b1}} >> amount_i);

    if (kind_i < 3'd4 && amount_i == '0) begin
      assert_zero_pass_R1: assert (result_o == operand_i && carry_o == carry_i)
        else $error("zero amount altered operand");
    end
    if (kind_i == 3'd0 && amount_i != '0 && amount_i < AW'(DW)) begin
      assert_lsl_zero_fill_R2: assert ((result_o & low_mask) == '0)
        else $error("left shift fill not zero");
    end
    if ((kind_i == 3'd0 || kind_i == 3'd1) && amount_i >= AW'(DW)) begin
      assert_wide_clears_R3: assert (result_o == '0)
        else $error("wide logical shift not zero");
    end
    if (kind_i == 3'd2 && amount_i != '0 && amount_i < AW'(DW)) begin
      assert_asr_sign_fill_R5: assert ((result_o & high_mask) == (operand_i[DW-1] ? high_mask : '0))
        else $error("arithmetic fill wrong");
    end
    if (kind_i == 3'd3 && amount_i != '0) begin
      assert_ror_carry_R6: assert (carry_o == result_o[DW-1])
        else $error("rotate carry mismatch");
    end
    if (kind_i == 3'd4) begin
      assert_rrx_R7: assert (result_o == {carry_i, operand_i[DW-1:1]} && carry_o == operand_i[0])
        else $error("rrx wrong");
    end
    if (kind_i > 3'd4) begin
      assert_unused_pass_R8: assert (result_o == operand_i && carry_o == carry_i)
        else $error("unused kind not pass-through");
    end
  end
endmodule

bind barrel_shifter barrel_shifter_chk #(.DW(DW), .AW(AW)) u_chk (
  .operand_i(operand_i),
  .kind_i   (kind_i),
  .amount_i (amount_i),
  .carry_i  (carry_i),
  .result_o (result_o),
  .carry_o  (carry_o)
);

// File: tb/barrel_shifter_tb.sv
module barrel_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand;
  logic [2:0]  kind;
  logic [5:0]  amount;
  logic        carry;
  logic [31:0] result;
  logic        carry_out;

  int unsigned n_total = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  barrel_shifter u_dut (
    .operand_i(operand),
    .kind_i   (kind),
    .amount_i (amount),
    .carry_i  (carry),
    .result_o (result),
    .carry_o  (carry_out)
  );

  function automatic string req_of(input int k, input int n);
    if (k > 4)            return "R8";
    if (k == 4)           return "R7";
    if (n == 0)           return "R1";
    if (k == 3)           return "R6";
    if (k == 2)           return "R5";
    if (n >= 32)          return "R3";
    if (k == 0)           return "R2";
    return "R4";
  endfunction

  task automatic ref_model(input logic [31:0] d, input int k, input int n, input logic c,
                           output logic [31:0] r, output logic co);
    int m;
    r = d; co = c;
    case (k)
      0: if (n != 0) begin
        r  = (n >= 32) ? 32'h0 : d << n;
        co = (n > 32) ? 1'b0 : d[32-n];
      end
      1: if (n != 0) begin
        r  = (n >= 32) ? 32'h0 : d >> n;
        co = (n > 32) ? 1'b0 : d[n-1];
      end
      2: if (n != 0) begin
        r  = $unsigned($signed(d) >>> n);
        co = (n >= 32) ? d[31] : d[n-1];
      end
      3: if (n != 0) begin
        m  = n % 32;
        r  = (m == 0) ? d : ((d >> m) | (d << (32 - m)));
        co = r[31];
      end
      4: begin
        r  = {c, d[31:1]};
        co = d[0];
      end
      default: ;
    endcase
  endtask

  task automatic check_one(input logic [31:0] d, input int k, input int n, input logic c);
    logic [31:0] er;
    logic        ec;
    operand = d; kind = 3'(k); amount = 6'(n); carry = c;
    #2;
    ref_model(d, k, n, c, er, ec);
    n_total++;
    if (result !== er || carry_out !== ec) begin
      n_fail++;
      $display("FAIL %s kind=%0d amt=%0d op=%h cin=%b: got %h/%b expected %h/%b",
               req_of(k, n), k, n, d, c, result, carry_out, er, ec);
    end
    #2;
  endtask

  logic [31:0] pats [8];

  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0001; pats[3] = 32'h7FFF_FFFE;
    pats[4] = 32'h1234_5678; pats[5] = 32'hDEAD_BEEF;
    pats[6] = 32'hA5A5_A5A5; pats[7] = 32'h0000_0001;
    operand = '0; kind = '0; amount = '0; carry = 1'b0;
    #20 rst_ni = 1'b1;
    // Full sweep over kinds R1..R8, amounts 0..63, patterns and carry.
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 64; n++)
        for (int p = 0; p < 8; p++)
          for (int c = 0; c < 2; c++)
            check_one(pats[p], k, n, c[0]);
    // Explicit boundary points: R6 rotate by 32, R3 shift by 32, R7 amount ignored.
    check_one(32'hC000_0003, 3, 32, 1'b0);
    check_one(32'h4000_0001, 0, 32, 1'b0);
    check_one(32'h8000_0002, 1, 32, 1'b1);
    check_one(32'h0000_0003, 4, 17, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: sweep incomplete, got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule